// File: doc/BRIEF.md
# Cascaded Pair-Sum Low-Pass Filter

This block is a low-pass FIR filter that needs no multipliers. It is a chain of identical two-tap stages. Each stage adds the sample it receives to the sample it accepted on the previous enabled clock, so its coefficients are fixed at one and one. When the stages are cascaded, the overall impulse response is the row of binomial coefficients C(S, j). Each extra stage deepens the stopband at the cost of one adder and two registers.

Samples arrive as signed words together with a strobe. The strobe travels down the chain beside the data, so every stage acts only on clocks that carry a real sample. A new sample can be accepted on every clock. The data path grows by one bit per stage, so the full-precision output can never wrap.

A build-time option keeps only the upper bits of the result. In that mode the output has the same width as the input and the DC gain is one.

Top module: `cascade_avg`

## Requirements
- R1: With S stages, each output equals the sum over j = 0..S of C(S, j) * x[n-j], where x[n] is the most recent accepted sample and x[n-j] is the sample accepted j accepted samples earlier.
- R2: After reset every delay register is zero, so the first output after reset equals the first accepted sample (full mode) and the second equals S times the first plus the second.
- R3: A clock with `in_en` low is ignored: its `in_smp` value does not enter the filter, and the stage-0 delay register keeps its value.
- R4: In full mode `out_smp` is IN_W + STAGES bits wide and holds the exact result without overflow, including a long run of the most negative input (-2^(IN_W-1) * 2^STAGES) and of the most positive input.
- R5: `out_vld` is high exactly STAGES clocks after the clock that accepted the matching sample. `out_smp` changes only on clocks where `out_vld` is high.
- R6: With `in_en` held high, a new sample is accepted on every clock and every one produces an output.
- R7: With SCALE = 1, `out_smp` is IN_W bits wide and equals the full-precision result arithmetically shifted right by STAGES (floor). A constant input c held for at least STAGES + 1 samples produces the output c.
- R8: A synchronous reset clears `out_vld`, `out_smp` and every stage register, and it discards samples that are still inside the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Sample strobe; `in_smp` is accepted on this clock |
| in_smp | input | IN_W | Signed input sample |
| out_vld | output | 1 | High on clocks that present a new output |
| out_smp | output | IN_W+STAGES, or IN_W when SCALE=1 | Signed filtered output |

## Verification
Several properties are checked on every cycle:
- `out_vld` matches a record of accepted strobes delayed by STAGES clocks.
- The output holds between strobes.
- Reset clears the output.
- The first delay register loads only accepted samples.

The arithmetic itself is checked only by the bench's scenarios:
- binomial weighting across sample gaps;
- the extremes of the input range;
- unity gain for every constant;
- the discarding of in-flight samples on reset.

The bench checks these against a model that sums binomial-weighted input history.

// File: rtl/cascade_avg.sv
module cascade_avg #(
  parameter int IN_W   = 12,
  parameter int STAGES = 10,
  parameter bit SCALE  = 1'b0
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          in_en,
  input  logic signed [IN_W-1:0]                        in_smp,
  output logic                                          out_vld,
  output logic signed [IN_W+(SCALE ? 0 : STAGES)-1:0]   out_smp
);

  localparam int FULL_W = IN_W + STAGES;

  for (genvar k = 0; k < STAGES; k++) begin : stg
    localparam int SW = IN_W + k;
    logic signed [SW-1:0] x;
    logic signed [SW-1:0] d_q;
    logic signed [SW:0]   y_q;
    logic                 v_i;
    logic                 v_q;

    if (k == 0) begin : g_src
      assign x   = in_smp;
      assign v_i = in_en;
    end else begin : g_lnk
      assign x   = stg[k-1].y_q;
      assign v_i = stg[k-1].v_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        d_q <= '0;
        y_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= v_i;
        if (v_i) begin
          d_q <= x;
          y_q <= {x[SW-1], x} + {d_q[SW-1], d_q};
        end
      end
    end
  end

  logic signed [FULL_W-1:0] full;
  assign full    = stg[STAGES-1].y_q;
  assign out_vld = stg[STAGES-1].v_q;

  if (SCALE) begin : g_unity
    assign out_smp = full[FULL_W-1:STAGES];
  end else begin : g_full
    assign out_smp = full;
  end

endmodule

module cascade_avg_chk #(
  parameter int IN_W   = 12,
  parameter int STAGES = 10,
  parameter bit SCALE  = 1'b0
) (
  input logic                                        clk,
  input logic                                        rst,
  input logic                                        in_en,
  input logic signed [IN_W-1:0]                      in_smp,
  input logic                                        out_vld,
  input logic signed [IN_W+(SCALE ? 0 : STAGES)-1:0] out_smp,
  input logic signed [IN_W-1:0]                      d0
);

  logic [STAGES-1:0] pipe;
  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= (pipe << 1) | STAGES'(in_en);
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_vld == pipe[STAGES-1]); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(rst)) |-> $stable(out_smp)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_vld && out_smp == '0)); // R8

  AST_DELAY_LOAD: assert property (@(posedge clk) disable iff (rst)
    in_en |=> (d0 == $past(in_smp))); // R1

  AST_DELAY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> $stable(d0)); // R3

endmodule

bind cascade_avg cascade_avg_chk #(.IN_W(IN_W), .STAGES(STAGES), .SCALE(SCALE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_en   (in_en),
  .in_smp  (in_smp),
  .out_vld (out_vld),
  .out_smp (out_smp),
  .d0      (stg[0].d_q)
);

// File: tb/cascade_avg_tb.sv
module cascade_avg_tb;

  localparam int TW = 4;
  localparam int TS = 3;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_en = 1'b0;
  logic signed [TW-1:0] in_smp = '0;
  logic out_vld, out_vld_s;
  logic signed [TW+TS-1:0] out_f;
  logic signed [TW-1:0]    out_s;

  always #4 clk = ~clk;

  cascade_avg #(.IN_W(TW), .STAGES(TS), .SCALE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_en(in_en), .in_smp(in_smp),
    .out_vld(out_vld), .out_smp(out_f));

  cascade_avg #(.IN_W(TW), .STAGES(TS), .SCALE(1'b1)) u_dut_s (
    .clk(clk), .rst(rst), .in_en(in_en), .in_smp(in_smp),
    .out_vld(out_vld_s), .out_smp(out_s));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int hist [0:TS];
  int qv [0:QN-1];
  int qc [0:QN-1];
  int wr = 0;
  int rd = 0;
  int last_f = 0;
  int last_s = 0;
  string tag = "R1";
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int binom(input int n, input int k);
    int r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst) begin
      last_f = 0;
      last_s = 0;
    end else if (out_vld) begin
      if (rd == wr) begin
        chk(1'b0, "R5", 1, 0);
      end else begin
        chk(int'(out_f) == qv[rd % QN], tag, int'(out_f), qv[rd % QN]);
        chk(int'(out_s) == (qv[rd % QN] >>> TS), "R7", int'(out_s), qv[rd % QN] >>> TS);
        chk(cyc == qc[rd % QN] + TS, "R5", cyc, qc[rd % QN] + TS);
        rd++;
      end
      last_f = int'(out_f);
      last_s = int'(out_s);
    end else begin
      chk(int'(out_f) == last_f, "R5", int'(out_f), last_f);
      chk(out_vld_s == 1'b0, "R5", int'(out_vld_s), 0);
    end
  end

  task automatic step(input bit en, input int v);
    int full;
    @(negedge clk);
    in_en  = en;
    in_smp = TW'(v);
    if (en) begin
      for (int j = TS; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = int'(in_smp);
      full = 0;
      for (int j = 0; j <= TS; j++) full += binom(TS, j) * hist[j];
      qv[wr % QN] = full;
      qc[wr % QN] = cyc;
      wr++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < TS + 3; i++) step(1'b0, i * 5 - 7);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_en = 1'b0;
    rd = wr;
    for (int j = 0; j <= TS; j++) hist[j] = 0;
    @(negedge clk);
    #2;
    // R8: registers cleared after a reset edge
    chk(out_vld == 1'b0, "R8", int'(out_vld), 0);
    chk(out_f == '0, "R8", int'(out_f), 0);
    chk(out_s == '0, "R8", int'(out_s), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    for (int j = 0; j <= TS; j++) hist[j] = 0;
    do_reset();

    // R2: first output is the first sample, second is S*first + second
    tag = "R2";
    step(1'b1, 5);
    step(1'b1, -2);
    drain();
    chk(last_f == 3 * 5 + 5 * 0 - 2 + 0, "R2", last_f, TS * 5 - 2);

    // R1 R6: exhaustive pairs at full rate
    tag = "R6";
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++) begin
        step(1'b1, a);
        step(1'b1, b);
      end
    drain();

    // R4: extremes
    tag = "R4";
    for (int i = 0; i < TS + 2; i++) step(1'b1, -8);
    drain();
    chk(last_f == -64, "R4", last_f, -64);
    for (int i = 0; i < TS + 2; i++) step(1'b1, 7);
    drain();
    chk(last_f == 56, "R4", last_f, 56);

    // R3: gaps; values on disabled clocks must be ignored
    tag = "R3";
    for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)) - 8);
    drain();

    // R7: unity gain for every constant
    tag = "R7";
    for (int c = -8; c < 8; c++) begin
      for (int i = 0; i < TS + 1; i++) step(1'b1, c);
      drain();
      chk(last_s == c, "R7", last_s, c);
    end

    // R8: reset with samples in flight, then R2 restart
    tag = "R8";
    step(1'b1, 6);
    step(1'b1, -5);
    do_reset();
    tag = "R2";
    step(1'b1, -3);
    drain();
    chk(last_f == -3, "R2", last_f, -3);
    chk(rd == wr, "R8", rd, wr);

    finish_run();
  end

endmodule